// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Latch

This block is a small register file on an 8-bit processor bus. It holds the state used to drive a bank of seven-segment digits. The bank is organised as a number of groups, four by default, and each group has as many digit columns as the data byte has bits. Software writes a one-hot column byte and a segment pattern. It then writes a group mask. That last write copies the low seven bits of the pattern into the chosen column of every group named in the mask. The register file also stores a byte of LED enables and a byte of keyboard lines, which are read back but drive nothing inside the block.

All digit latches appear together on one flat output bus. Digit `d` occupies bits `[7*d+6 : 7*d]`, and digit `d` belongs to group `d / 8` and column `d % 8`. Reads are combinational. Writes take effect at the rising clock edge on which the write strobe is sampled high.

Top module: `dispLatchBank`

## Requirements
- R1: After reset, the column, LED, keyboard, segment and group registers all read as zero, and every digit latch holds 0x7F (all segments lit).
- R2: Offsets 0 (column select), 1 (LED enable), 2 (keyboard) and 3 (segment pattern) each read back the full 8-bit value last written to that offset.
- R3: Offset 4 (group mask) stores only the low 4 bits of a write, and a read of it returns zero in bits 7:4.
- R4: A write to offsets 5, 6 or 7 changes no register and no digit latch, and a read of those offsets returns zero.
- R5: A write to offset 4 while the column byte has exactly one bit set, at position k, loads digit 8*i+k for every bit i set in the written mask.
- R6: The value loaded into a digit is bits 6:0 of the segment register, and bit 7 of that register is discarded.
- R7: A write to offset 4 while the column byte is zero or has two or more bits set leaves every digit latch unchanged.
- R8: Writes to offsets 0 through 3 only store their value and never change a digit latch.
- R9: Several mask bits in one write update the same column in each selected group at a single clock edge, and groups whose mask bit is clear keep their digits.
- R10: `busRdData` is zero while `busRd` is low. When `busRd` and `busWr` are both high in the same cycle, the read returns the value the register held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 3 | Register offset |
| busWrData | input | 8 | Write data |
| busWr | input | 1 | Write strobe, sampled at the clock edge |
| busRd | input | 1 | Read strobe |
| busRdData | output | 8 | Read data, combinational |
| digitSegs | output | 224 | All digit latches, 7 bits per digit, digit 0 in the low bits |

## Verification
Two things can happen in the same cycle: a read of a register and a write to that same register. This happens most often at the group mask, where the write also loads the digits. The bench raises both strobes together at offset 4 with a new mask. It expects the read to return the old mask, and it expects the digits to reflect the new mask once the edge has passed. The multi-group load is a second case where several latches change together. It is provoked with masks that have two to four bits set, and the bench judges it by comparing every digit against a model after each write.

// File: rtl/dispPkg.sv
package dispPkg;

  typedef enum logic [2:0] {
    SEL_SCAN  = 3'd0,
    SEL_LED   = 3'd1,
    SEL_KEY   = 3'd2,
    SEL_SEG   = 3'd3,
    SEL_GROUP = 3'd4,
    SEL_NONE  = 3'd5
  } readSelT;

  typedef struct packed {
    logic    wrScan;
    logic    wrLed;
    logic    wrKey;
    logic    wrSeg;
    logic    wrGroup;
    logic    rdEn;
    readSelT rdSel;
  } busCtlT;

endpackage

// File: rtl/dispBusCtl.sv
module dispBusCtl
  import dispPkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output busCtlT            ctl
);

  always_comb begin
    ctl         = '0;
    ctl.rdEn    = busRd;
    ctl.rdSel   = SEL_NONE;
    case (busAddr)
      ADDR_W'(0): begin ctl.wrScan  = busWr; ctl.rdSel = SEL_SCAN;  end
      ADDR_W'(1): begin ctl.wrLed   = busWr; ctl.rdSel = SEL_LED;   end
      ADDR_W'(2): begin ctl.wrKey   = busWr; ctl.rdSel = SEL_KEY;   end
      ADDR_W'(3): begin ctl.wrSeg   = busWr; ctl.rdSel = SEL_SEG;   end
      ADDR_W'(4): begin ctl.wrGroup = busWr; ctl.rdSel = SEL_GROUP; end
      default:    ctl.rdSel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/dispDatapath.sv
module dispDatapath
  import dispPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_GROUPS = 4,
  parameter int SEG_W      = 7
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  busCtlT                               ctl,
  input  logic [DATA_W-1:0]                    busWrData,
  output logic [DATA_W-1:0]                    busRdData,
  output logic [NUM_GROUPS*DATA_W*SEG_W-1:0]   digitSegs
);

  localparam int COLS       = DATA_W;
  localparam int NUM_DIGITS = NUM_GROUPS * COLS;
  localparam logic [SEG_W-1:0] SEG_ALL_ON = '1;

  logic [DATA_W-1:0]     scanReg;
  logic [DATA_W-1:0]     ledReg;
  logic [DATA_W-1:0]     keyReg;
  logic [DATA_W-1:0]     segReg;
  logic [NUM_GROUPS-1:0] groupReg;
  logic                  scanHot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanReg  <= '0;
      ledReg   <= '0;
      keyReg   <= '0;
      segReg   <= '0;
      groupReg <= '0;
    end else begin
      if (ctl.wrScan)  scanReg  <= busWrData;
      if (ctl.wrLed)   ledReg   <= busWrData;
      if (ctl.wrKey)   keyReg   <= busWrData;
      if (ctl.wrSeg)   segReg   <= busWrData;
      if (ctl.wrGroup) groupReg <= busWrData[NUM_GROUPS-1:0];
    end
  end

  // exactly one column bit set
  assign scanHot = (scanReg != '0) && ((scanReg & (scanReg - 1'b1)) == '0);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    for (genvar k = 0; k < COLS; k++) begin : gCol
      logic [SEG_W-1:0] digitQ;
      logic             loadEn;
      assign loadEn = ctl.wrGroup && busWrData[g] && scanHot && scanReg[k];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       digitQ <= SEG_ALL_ON;
        else if (loadEn) digitQ <= segReg[SEG_W-1:0];
      end
      assign digitSegs[(g*COLS+k)*SEG_W +: SEG_W] = digitQ;
    end
  end

  always_comb begin
    busRdData = '0;
    if (ctl.rdEn) begin
      case (ctl.rdSel)
        SEL_SCAN:  busRdData = scanReg;
        SEL_LED:   busRdData = ledReg;
        SEL_KEY:   busRdData = keyReg;
        SEL_SEG:   busRdData = segReg;
        SEL_GROUP: busRdData[NUM_GROUPS-1:0] = groupReg;
        default:   busRdData = '0;
      endcase
    end
  end

  if (NUM_DIGITS < 1) begin : gBadSize
    initial $error("dispDatapath needs at least one digit");
  end

endmodule

// File: rtl/dispLatchBank.sv
module dispLatchBank
  import dispPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_GROUPS = 4,
  parameter int SEG_W      = 7,
  parameter int ADDR_W     = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [ADDR_W-1:0]                  busAddr,
  input  logic [DATA_W-1:0]                  busWrData,
  input  logic                               busWr,
  input  logic                               busRd,
  output logic [DATA_W-1:0]                  busRdData,
  output logic [NUM_GROUPS*DATA_W*SEG_W-1:0] digitSegs
);

  busCtlT ctl;

  dispBusCtl #(.ADDR_W(ADDR_W)) uCtl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .ctl     (ctl)
  );

  dispDatapath #(
    .DATA_W     (DATA_W),
    .NUM_GROUPS (NUM_GROUPS),
    .SEG_W      (SEG_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .digitSegs (digitSegs)
  );

endmodule

// File: rtl/dispLatchBank_chk.sv
module dispLatchBank_chk #(
  parameter int DATA_W     = 8,
  parameter int NUM_GROUPS = 4,
  parameter int SEG_W      = 7,
  parameter int ADDR_W     = 3
) (
  input logic                               clk,
  input logic                               rstN,
  input logic [ADDR_W-1:0]                  busAddr,
  input logic [DATA_W-1:0]                  busWrData,
  input logic                               busWr,
  input logic                               busRd,
  input logic [DATA_W-1:0]                  busRdData,
  input logic [NUM_GROUPS*DATA_W*SEG_W-1:0] digitSegs
);

  logic [DATA_W-1:0] shadowScan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             shadowScan <= '0;
    else if (busWr && busAddr == ADDR_W'(0)) shadowScan <= busWrData;
  end

  // R10: idle read port is zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> busRdData == '0);

  // R3: upper group bits read zero
  a_r3_group_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == ADDR_W'(4)) |-> busRdData[DATA_W-1:NUM_GROUPS] == '0);

  // R4: unmapped offsets read zero
  a_r4_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr > ADDR_W'(4)) |-> busRdData == '0);

  // R4: unmapped writes leave digits alone
  a_r4_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr > ADDR_W'(4)) |=> $stable(digitSegs));

  // R8: plain register writes leave digits alone
  a_r8_plain_write_inert: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr < ADDR_W'(4)) |=> $stable(digitSegs));

  // R7: non-one-hot column byte blocks the load
  a_r7_bad_scan_inert: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(4) && $countones(shadowScan) != 1) |=> $stable(digitSegs));

  // R2: segment register read back after write
  a_r2_seg_readback: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(3)) |=>
      ((busRd && busAddr == ADDR_W'(3)) -> busRdData == $past(busWrData)));

endmodule

bind dispLatchBank dispLatchBank_chk #(
  .DATA_W(DATA_W), .NUM_GROUPS(NUM_GROUPS), .SEG_W(SEG_W), .ADDR_W(ADDR_W)
) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
  .busWr(busWr), .busRd(busRd), .busRdData(busRdData), .digitSegs(digitSegs)
);

// File: tb/dispLatchBank_test.sv
module dispLatchBank_test;

  localparam int CLK_PERIOD = 10;
  localparam int NG = 4;
  localparam int ND = NG * 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busRdData;
  logic [ND*7-1:0] digitSegs;

  int checks = 0;
  int fails  = 0;

  logic [7:0] mScan, mLed, mKey, mSeg;
  logic [3:0] mGroup;
  logic [6:0] mDig [ND];

  always #(CLK_PERIOD/2) clk = ~clk;

  dispLatchBank uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData), .digitSegs(digitSegs)
  );

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    report();
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit oneHot(input logic [7:0] v);
    return (v != 0) && ((v & (v - 8'd1)) == 0);
  endfunction

  function automatic logic [7:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return mScan;
      3'd1: return mLed;
      3'd2: return mKey;
      3'd3: return mSeg;
      3'd4: return {4'b0, mGroup};
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelReset();
    mScan = 0; mLed = 0; mKey = 0; mSeg = 0; mGroup = 0;
    for (int d = 0; d < ND; d++) mDig[d] = 7'h7F;
  endtask

  task automatic modelWrite(input logic [2:0] a, input logic [7:0] v);
    case (a)
      3'd0: mScan = v;
      3'd1: mLed = v;
      3'd2: mKey = v;
      3'd3: mSeg = v;
      3'd4: begin
        mGroup = v[3:0];
        if (oneHot(mScan))
          for (int g = 0; g < NG; g++)
            if (v[g])
              for (int k = 0; k < 8; k++)
                if (mScan[k]) mDig[g*8+k] = mSeg[6:0];
      end
      default: ;
    endcase
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk);
    busAddr = a; busWrData = v; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    modelWrite(a, v);
  endtask

  task automatic doRead(input logic [2:0] a, input string req);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1;
    check(busRdData == expRead(a), req, busRdData, expRead(a));
    busRd = 1'b0;
  endtask

  task automatic checkDigits(input string req);
    int bad;
    bad = -1;
    #1;
    for (int d = 0; d < ND; d++)
      if (digitSegs[d*7 +: 7] !== mDig[d] && bad < 0) bad = d;
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, {req, " digit mismatch"}, {bad[7:0], 1'b0, digitSegs[bad*7 +: 7]},
               {bad[7:0], 1'b0, mDig[bad]});
  endtask

  initial begin
    void'($urandom(32'd20240517));
    modelReset();
    #(CLK_PERIOD * 3);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    checkDigits("R1 reset digits");
    for (int a = 0; a < 5; a++) doRead(3'(a), "R1 reset register");
    // R10: idle read port
    #1 check(busRdData == 8'h00, "R10 idle read zero", busRdData, 0);

    // R2 / R8: plain registers
    doWrite(3'd1, 8'hC3); doWrite(3'd2, 8'h5A);
    doWrite(3'd0, 8'h04); doWrite(3'd3, 8'hA5);
    for (int a = 0; a < 4; a++) doRead(3'(a), "R2 readback");
    checkDigits("R8 plain writes keep digits");

    // R5 / R6: single group load, bit 7 dropped (0xA5 -> 0x25 in digit 2)
    doWrite(3'd4, 8'h01);
    checkDigits("R5 R6 single group load");
    check(digitSegs[2*7 +: 7] == 7'h25, "R6 low seven bits", digitSegs[2*7 +: 7], 7'h25);

    // R3: upper mask bits dropped
    doWrite(3'd4, 8'hF0);
    doRead(3'd4, "R3 group upper bits zero");
    checkDigits("R3 upper-only mask loads nothing");

    // R9: two groups at once, column 7
    doWrite(3'd0, 8'h80); doWrite(3'd3, 8'h12);
    doWrite(3'd4, 8'h0A);
    checkDigits("R9 multi group same column");
    check(digitSegs[31*7 +: 7] == 7'h12, "R9 group 3 column 7", digitSegs[31*7 +: 7], 7'h12);
    doWrite(3'd4, 8'h0F);
    checkDigits("R9 all groups");

    // R7: zero and multi-bit column bytes
    doWrite(3'd3, 8'h3C);
    doWrite(3'd0, 8'h00); doWrite(3'd4, 8'h0F);
    checkDigits("R7 zero column");
    doWrite(3'd0, 8'h81); doWrite(3'd4, 8'h0F);
    checkDigits("R7 two-bit column");

    // R4: unmapped offsets
    doWrite(3'd0, 8'h10);
    for (int a = 5; a < 8; a++) begin
      doWrite(3'(a), 8'hFF);
      doRead(3'(a), "R4 unmapped read");
    end
    for (int a = 0; a < 5; a++) doRead(3'(a), "R4 registers untouched");
    checkDigits("R4 digits untouched");

    // R10: read and write of the group mask in one cycle
    @(negedge clk);
    busAddr = 3'd4; busWrData = 8'h05; busWr = 1'b1; busRd = 1'b1;
    #1 check(busRdData == {4'b0, mGroup}, "R10 read sees old mask", busRdData, {4'b0, mGroup});
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0;
    modelWrite(3'd4, 8'h05);
    checkDigits("R10 R5 load on simultaneous access");
    doRead(3'd4, "R10 mask after edge");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [2:0] a;
      logic [7:0] v;
      a = 3'($urandom % 8);
      v = 8'($urandom);
      if (a == 3'd0 && ($urandom % 4) != 0) v = 8'd1 << ($urandom % 8);
      doWrite(a, v);
      checkDigits("R5 R7 R8 R9 random");
      doRead(3'($urandom % 8), "R2 R3 R4 random read");
    end

    report();
  end

endmodule